// File: doc/BRIEF.md
# Loss-of-Signal Detector with Receive Data Mute

This block watches one channel of recovered serial data and decides whether a real signal is present. It has two sources of evidence. An internal transition monitor counts sample-clock cycles between data edges. An external signal-detect line comes from the optical module, and a strap input sets whether that line is active high or active low. When either source reports absence, the combined loss-of-signal flag rises and the serial data output is forced to zero. Line noise then cannot reach the framer as data.

The internal monitor is deliberately asymmetric. Loss is declared quickly, as soon as the data stays quiet for longer than a short threshold. Recovery is slow. The monitor runs a long window timer, and that timer restarts every time a quiet gap longer than the short threshold appears. Only a whole window with no such gap clears the internal flag. Quiet gaps at or below the threshold are allowed inside the window. A disable input removes the internal monitor and its muting; the external detect still applies. A one-cycle pulse marks every change of the combined flag.

Both intervals are parameters counted in sample-clock cycles: `DECL_CYCLES` for the declare threshold and `CLEAR_CYCLES` for the clearing window.

Top module: `los_mute_detector`

## Requirements
- R1: A run of more than `DECL_CYCLES` consecutive samples with no data transition declares internal loss of signal. The flag is visible in the cycle after the sample number `DECL_CYCLES+1` of the run.
- R2: A transition-free run of at most `DECL_CYCLES` samples does not declare loss of signal.
- R3: Once declared, internal loss clears after `CLEAR_CYCLES` consecutive samples in which no over-threshold gap occurs. Quiet gaps of at most `DECL_CYCLES` samples inside that span count toward it.
- R4: An over-threshold quiet gap while loss is declared restarts the clearing window from zero.
- R5: The external detect produces loss of signal in the same cycle, with no filtering. With `sd_pol`=1, signal is present when `sig_det`=1. With `sd_pol`=0, signal is present when `sig_det`=0.
- R6: While `los` is 1, `data_out` is 0. Otherwise `data_out` equals `rx_data` in the same cycle.
- R7: While `mon_dis` is 1, the internal monitor neither declares nor mutes, and a pending internal loss is dropped at once. The external detect still sets `los`.
- R8: `los_chg` is 1 for exactly the cycle in which `los` differs from its value in the previous cycle.
- R9: During and right after reset, the internal flag is clear and `los_chg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Sampled recovered serial data |
| sig_det | input | 1 | External signal-detect from the optical module |
| sd_pol | input | 1 | 1: detect is active high; 0: detect is active low |
| mon_dis | input | 1 | 1 disables the internal transition monitor |
| data_out | output | 1 | Serial data, forced to 0 during loss of signal |
| los | output | 1 | Combined loss-of-signal flag |
| los_chg | output | 1 | One-cycle pulse on each change of `los` |

## Verification
The bench sweeps quiet-run lengths from zero to two past the threshold. An off-by-one in the declare compare shows up as a flag one sample early or late. It then counts recovery toggles one by one, so a window that clears a cycle early or late is caught. It runs the clearing window twice more: once with a permitted gap inside it, which a design that restarts on any gap would clear too late, and once with an over-threshold gap, which a design without restart would clear after only a few samples. It also sweeps every combination of detect level, polarity and monitor-disable, and checks the change pulse at each flag edge. Swapped polarity, muting left active under disable, or a pulse longer than one cycle each fail these checks.

// File: rtl/los_mute_detector.sv
module los_mute_detector #(
  parameter int unsigned DECL_CYCLES  = 389,
  parameter int unsigned CLEAR_CYCLES = 19907
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_data,
  input  logic sig_det,
  input  logic sd_pol,
  input  logic mon_dis,
  output logic data_out,
  output logic los,
  output logic los_chg
);
  localparam int GW = $clog2(DECL_CYCLES + 1);
  localparam int WW = $clog2(CLEAR_CYCLES);

  logic          prev_data, int_los, los_q;
  logic [GW-1:0] gap_cnt;
  logic [WW-1:0] win_cnt;

  wire edge_seen = rx_data ^ prev_data;
  wire long_gap  = !edge_seen && (gap_cnt == GW'(DECL_CYCLES));
  wire ext_los   = sig_det ^ sd_pol;

  assign los      = ext_los | (int_los & ~mon_dis);
  assign data_out = rx_data & ~los;
  assign los_chg  = los ^ los_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_data <= 1'b0;
      gap_cnt   <= '0;
      win_cnt   <= '0;
      int_los   <= 1'b0;
      los_q     <= 1'b0;
    end else begin
      prev_data <= rx_data;
      los_q     <= los;
      if (mon_dis) begin
        gap_cnt <= '0;
        win_cnt <= '0;
        int_los <= 1'b0;
      end else begin
        if (edge_seen)      gap_cnt <= '0;
        else if (!long_gap) gap_cnt <= gap_cnt + 1'b1;

        if (!int_los) begin
          win_cnt <= '0;
          if (long_gap) int_los <= 1'b1;
        end else if (long_gap) begin
          win_cnt <= '0;
        end else if (win_cnt == WW'(CLEAR_CYCLES - 1)) begin
          win_cnt <= '0;
          int_los <= 1'b0;
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end
    end
  end

  p_declare_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_dis && long_gap) |=> int_los);

  p_clear_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(int_los) && !$past(mon_dis)) |-> ($past(win_cnt) == WW'(CLEAR_CYCLES - 1)));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_dis && int_los && long_gap) |=> (int_los && win_cnt == '0));

  p_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det != sd_pol) |-> los);

  p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> !data_out);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mon_dis |=> !int_los);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los) || $fell(los)) |-> los_chg);
endmodule

// File: tb/los_mute_detector_tb.sv
module los_mute_detector_tb;
  localparam int DECL = 4;
  localparam int CLR  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_data = 1'b0, sig_det = 1'b1, sd_pol = 1'b1, mon_dis = 1'b0;
  logic data_out, los, los_chg;
  logic cur = 1'b0;
  logic done = 1'b0;
  int   vec = 0, err = 0;

  always #2.5 clk = ~clk;

  los_mute_detector #(.DECL_CYCLES(DECL), .CLEAR_CYCLES(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .sig_det(sig_det),
    .sd_pol(sd_pol), .mon_dis(mon_dis), .data_out(data_out),
    .los(los), .los_chg(los_chg));

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    vec++;
    if (got !== exp) begin
      err++;
      $display("FAIL %s %s: got %b exp %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic put(input logic d);
    @(negedge clk);
    rx_data = d;
    cur = d;
    #1;
  endtask

  task automatic tog();   put(~cur); endtask
  task automatic quiet(); put(cur);  endtask

  task automatic recover();
    for (int i = 0; i < CLR + 2; i++) tog();
  endtask

  task automatic declare();
    recover();
    for (int i = 0; i < DECL + 1; i++) quiet();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      err++;
      vec++;
      $display("FAIL R9 watchdog: got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    logic prev_exp;
    repeat (3) @(negedge clk);
    #1;
    chk(los, 1'b0, "R9", "los in reset");
    chk(los_chg, 1'b0, "R9", "los_chg in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(los_chg, 1'b0, "R9", "los_chg after reset");

    // R1 / R2: sweep quiet-run length across the threshold
    for (int n = 0; n <= DECL + 2; n++) begin
      recover();
      for (int i = 0; i < n; i++) quiet();
      tog();
      chk(los, (n >= DECL + 1), "R1_R2", $sformatf("los after %0d quiet", n));
      chk(data_out, (n >= DECL + 1) ? 1'b0 : cur, "R6", $sformatf("data_out after %0d quiet", n));
    end

    // R3 / R8: exact clear boundary with pulses at both edges
    recover();
    for (int i = 0; i < DECL + 1; i++) quiet();
    tog();
    chk(los, 1'b1, "R1", "declared");
    chk(los_chg, 1'b1, "R8", "pulse on rise");
    for (int k = 2; k <= CLR; k++) begin
      tog();
      if (k == 2) chk(los_chg, 1'b0, "R8", "pulse one cycle");
      chk(los, 1'b1, "R3", $sformatf("still lost at toggle %0d", k));
      chk(data_out, 1'b0, "R6", "muted while lost");
    end
    tog();
    chk(los, 1'b0, "R3", "cleared after full window");
    chk(los_chg, 1'b1, "R8", "pulse on fall");
    chk(data_out, cur, "R6", "data passes after clear");
    tog();
    chk(los_chg, 1'b0, "R8", "fall pulse one cycle");

    // R3: a permitted gap inside the window still counts
    declare();
    for (int i = 0; i < 5; i++) tog();
    for (int i = 0; i < DECL; i++) quiet();
    for (int j = 1; j <= CLR - 5 - DECL; j++) begin
      tog();
      chk(los, 1'b1, "R3", $sformatf("short-gap window toggle %0d", j));
    end
    tog();
    chk(los, 1'b0, "R3", "short gap does not restart window");

    // R4: an over-threshold gap restarts the window
    declare();
    for (int i = 0; i < 10; i++) tog();
    for (int i = 0; i < DECL + 1; i++) quiet();
    for (int j = 1; j <= CLR; j++) begin
      tog();
      chk(los, 1'b1, "R4", $sformatf("restarted window toggle %0d", j));
    end
    tog();
    chk(los, 1'b0, "R4", "clears after restarted window");

    // R7: monitor disable
    declare();
    mon_dis = 1'b1;
    tog();
    chk(los, 1'b0, "R7", "pending loss dropped");
    chk(data_out, cur, "R7", "no mute under disable");
    for (int i = 0; i < 3 * DECL; i++) begin
      quiet();
      chk(los, 1'b0, "R7", $sformatf("quiet %0d ignored", i));
    end
    sig_det = 1'b0;
    tog();
    chk(los, 1'b1, "R7", "external path under disable");
    chk(data_out, 1'b0, "R7", "external mute under disable");
    sig_det = 1'b1;
    mon_dis = 1'b0;
    recover();

    // R5 / R6 / R8: sweep detect level, polarity, disable
    prev_exp = los;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++) begin
          logic e;
          @(negedge clk);
          sd_pol  = p[0];
          sig_det = s[0];
          mon_dis = m[0];
          rx_data = ~cur;
          cur     = ~cur;
          #1;
          e = (s[0] != p[0]);
          chk(los, e, "R5", $sformatf("pol=%0d det=%0d dis=%0d", p, s, m));
          chk(data_out, e ? 1'b0 : cur, "R6", "data vs flag");
          chk(los_chg, e != prev_exp, "R8", "pulse on external change");
          prev_exp = e;
        end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule